// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block is the 8-bit status register of a serial port. Five event flags (transmit data empty, receive full, overrun, framing error, parity error) are raised by single-cycle pulses from the transmit and receive logic. Software may only lower a flag through a two-step handshake. First it reads the register while the flag shows 1. Then it writes 0 to that bit position. Hardware can never be overruled by a blind write, and a flag raised again after the read cannot be lost by a stale clear.

The register also holds three control bits. A transmit-end bit is driven only by hardware pulses. A received multiprocessor bit is loaded by hardware. A transmit multiprocessor bit is plain read/write and is also driven out to the transmitter. Power-on reset and the two standby requests put the register back to its initial value. The manual reset input leaves it untouched.

Top module: `ser_status_reg`

## Requirements
- R1: While the asynchronous active-low power-on reset `rst_n` is low, `rdata` reads 0x84. Bit 7 is transmit-empty, bit 6 receive-full, bit 5 overrun, bit 4 framing error, bit 3 parity error, bit 2 transmit-end, bit 1 received multiprocessor bit, bit 0 transmit multiprocessor bit.
- R2: A one-cycle pulse on an event input sets the matching flag. It is visible on `rdata` after the next rising clock edge.
- R3: Writing 1 to any of bits 7..3 never sets a flag and never changes it.
- R4: Writing 0 to a flag does not clear it unless a read strobe was given while that flag already read 1. This holds whether the flag was never read, or was read only while it was 0.
- R5: After a read strobe that saw a flag at 1, a later write with 0 in that bit clears it on the next edge. Flags written with 1 in the same write keep their value.
- R6: A set pulse in the same cycle as a clearing write leaves the flag at 1. Any hardware set also cancels the earlier read, so a further read is needed before a clear works.
- R7: Writes never change bit 2 or bit 1. Bit 2 goes to 1 on `tx_end_set` and to 0 on `tx_end_clr`. Bit 1 takes `mpb_val` on `mpb_load`.
- R8: Every write copies `wdata[0]` into bit 0, even when the flag bits of that write are ignored. `mpbt_o` equals bit 0.
- R9: A one-cycle `hw_stby` or `sw_stby` request sets the register to 0x84 on the next edge and cancels every pending read-before-clear.
- R10: `man_rst` has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst | input | 1 | Manual reset; does not touch this register |
| hw_stby | input | 1 | Hardware standby initialisation request |
| sw_stby | input | 1 | Software standby initialisation request |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Register contents |
| ev_tx_empty | input | 1 | Set pulse, transmit data empty (bit 7) |
| ev_rx_full | input | 1 | Set pulse, receive full (bit 6) |
| ev_overrun | input | 1 | Set pulse, overrun (bit 5) |
| ev_frame_err | input | 1 | Set pulse, framing error (bit 4) |
| ev_parity_err | input | 1 | Set pulse, parity error (bit 3) |
| tx_end_set | input | 1 | Sets transmit-end bit |
| tx_end_clr | input | 1 | Clears transmit-end bit |
| mpb_load | input | 1 | Loads received multiprocessor bit |
| mpb_val | input | 1 | Value for received multiprocessor bit |
| mpbt_o | output | 1 | Transmit multiprocessor bit |

## Verification
The read-before-clear state of each flag cannot be seen at the ports. A fault in it shows only on the edge after a clearing write: a flag stays at 1 when it should fall, or falls when no qualifying read came first. The directed sequences therefore pair each write with the exact read history before it, including reads taken while the flag was 0 and sets that arrive after the read. A wrongly set or dropped flag bit appears on `rdata` one edge after the offending pulse or write.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_EVT  = 5;
  localparam int EVT_LSB  = 3;
  localparam int TEND_POS = 2;
  localparam int MPB_POS  = 1;
  localparam int MPBT_POS = 0;
  localparam logic [REG_W-1:0] INIT_VAL = 8'h84;
endpackage

// File: rtl/ssr_evt_flag.sv
module ssr_evt_flag #(
  parameter logic INIT_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr_ok;

  assign clr_ok = wr_i && !wbit_i && arm_q;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (init_i) begin
      flag_d = INIT_BIT;
      arm_d  = 1'b0;
    end else if (set_i) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (clr_ok) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (rd_i && flag_q) begin
      arm_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= INIT_BIT;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ssr_ctl_bits.sv
module ssr_ctl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic tend_set_i,
  input  logic tend_clr_i,
  input  logic mpb_ld_i,
  input  logic mpb_val_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic tend_o,
  output logic mpb_o,
  output logic mpbt_o
);
  logic tend_q, tend_d;
  logic mpb_q, mpb_d;
  logic mpbt_q, mpbt_d;

  always_comb begin
    tend_d = tend_q;
    mpb_d  = mpb_q;
    mpbt_d = mpbt_q;
    if (init_i) begin
      tend_d = 1'b1;
      mpb_d  = 1'b0;
      mpbt_d = 1'b0;
    end else begin
      if (tend_set_i)      tend_d = 1'b1;
      else if (tend_clr_i) tend_d = 1'b0;
      if (mpb_ld_i)        mpb_d  = mpb_val_i;
      if (wr_i)            mpbt_d = wbit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
      mpb_q  <= 1'b0;
      mpbt_q <= 1'b0;
    end else begin
      tend_q <= tend_d;
      mpb_q  <= mpb_d;
      mpbt_q <= mpbt_d;
    end
  end

  assign tend_o = tend_q;
  assign mpb_o  = mpb_q;
  assign mpbt_o = mpbt_q;
endmodule

// File: rtl/ser_status_reg.sv
module ser_status_reg
  import ssr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             man_rst,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             ev_tx_empty,
  input  logic             ev_rx_full,
  input  logic             ev_overrun,
  input  logic             ev_frame_err,
  input  logic             ev_parity_err,
  input  logic             tx_end_set,
  input  logic             tx_end_clr,
  input  logic             mpb_load,
  input  logic             mpb_val,
  output logic             mpbt_o
);
  logic               init_req;
  logic [NUM_EVT-1:0] set_vec;
  logic [NUM_EVT-1:0] flag_vec;
  logic               tend_b, mpb_b, mpbt_b;
  logic               unused_man_rst;

  // Manual reset is deliberately not wired into any state.
  assign unused_man_rst = man_rst;
  assign init_req = hw_stby | sw_stby;
  assign set_vec  = {ev_tx_empty, ev_rx_full, ev_overrun, ev_frame_err, ev_parity_err};

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    ssr_evt_flag #(.INIT_BIT(INIT_VAL[EVT_LSB+i])) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_i (init_req),
      .set_i  (set_vec[i]),
      .rd_i   (rd_en),
      .wr_i   (wr_en),
      .wbit_i (wdata[EVT_LSB+i]),
      .flag_o (flag_vec[i])
    );
  end

  ssr_ctl_bits u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_req),
    .tend_set_i (tx_end_set),
    .tend_clr_i (tx_end_clr),
    .mpb_ld_i   (mpb_load),
    .mpb_val_i  (mpb_val),
    .wr_i       (wr_en),
    .wbit_i     (wdata[MPBT_POS]),
    .tend_o     (tend_b),
    .mpb_o      (mpb_b),
    .mpbt_o     (mpbt_b)
  );

  always_comb begin
    rdata = '0;
    rdata[EVT_LSB +: NUM_EVT] = flag_vec;
    rdata[TEND_POS] = tend_b;
    rdata[MPB_POS]  = mpb_b;
    rdata[MPBT_POS] = mpbt_b;
  end

  assign mpbt_o = mpbt_b;
endmodule

// File: rtl/ser_status_reg_chk.sv
module ser_status_reg_chk
  import ssr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             hw_stby,
  input logic             sw_stby,
  input logic             wr_en,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] rdata,
  input logic [NUM_EVT-1:0] set_vec,
  input logic             tx_end_set,
  input logic             tx_end_clr,
  input logic             mpb_load,
  input logic             mpbt_o
);
  logic stby;
  assign stby = hw_stby | sw_stby;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_fchk
    // R3: a flag at 0 rises only through its set pulse or an init
    a_r3_no_rise_without_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdata[EVT_LSB+i] && !set_vec[i] && !stby) |=> !rdata[EVT_LSB+i]);
    // R2 / R6: a set pulse always wins
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec[i] && !stby) |=> rdata[EVT_LSB+i]);
    // R5: a flag falls only after a write with 0 in its position
    a_r5_fall_needs_write0: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rdata[EVT_LSB+i]) && !$past(stby)) |-> $past(wr_en && !wdata[EVT_LSB+i]));
  end

  // R7: read-only bits hold when no hardware update arrives
  a_r7_tend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_end_set && !tx_end_clr && !stby) |=> $stable(rdata[TEND_POS]));
  a_r7_mpb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mpb_load && !stby) |=> $stable(rdata[MPB_POS]));
  // R8: each write lands in the transmit multiprocessor bit
  a_r8_mpbt_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stby) |=> (rdata[MPBT_POS] == $past(wdata[MPBT_POS])));
  a_r8_mpbt_pin: assert property (@(posedge clk) disable iff (!rst_n)
    mpbt_o == rdata[MPBT_POS]);
  // R9: standby request restores the initial value
  a_r9_stby_init: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (rdata == INIT_VAL));
endmodule

bind ser_status_reg ser_status_reg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hw_stby    (hw_stby),
  .sw_stby    (sw_stby),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .set_vec    (set_vec),
  .tx_end_set (tx_end_set),
  .tx_end_clr (tx_end_clr),
  .mpb_load   (mpb_load),
  .mpbt_o     (mpbt_o)
);

// File: tb/ser_status_reg_tb.sv
`timescale 1ns/1ps
module ser_status_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       man_rst = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [4:0] ev = 5'b0;  // {tx_empty, rx_full, overrun, frame, parity}
  logic       te_set = 1'b0, te_clr = 1'b0, mpb_ld = 1'b0, mpb_v = 1'b0;
  logic       mpbt_o;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ser_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .man_rst(man_rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .ev_tx_empty(ev[4]), .ev_rx_full(ev[3]), .ev_overrun(ev[2]),
    .ev_frame_err(ev[1]), .ev_parity_err(ev[0]),
    .tx_end_set(te_set), .tx_end_clr(te_clr), .mpb_load(mpb_ld), .mpb_val(mpb_v),
    .mpbt_o(mpbt_o)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (rdata !== exp) begin
      n_err++;
      $display("FAIL %s: rdata=%02h expected=%02h", req, rdata, exp);
    end
  endtask

  task automatic idle();
    rd_en = 0; wr_en = 0; wdata = 8'h00; ev = 5'b0; te_set = 0; te_clr = 0;
    mpb_ld = 0; mpb_v = 0; hw_stby = 0; sw_stby = 0; man_rst = 0;
  endtask

  // inputs change at a falling edge, results are sampled at the next falling edge
  task automatic do_read();
    @(negedge clk); rd_en = 1; @(negedge clk); idle();
  endtask
  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wdata = d; @(negedge clk); idle();
  endtask
  task automatic do_set(input logic [4:0] e);
    @(negedge clk); ev = e; @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1 reset value", 8'h84);
  endtask

  task automatic t_write_ones();
    do_write(8'hFE);
    chk("R3 write ones", 8'h84);
  endtask

  task automatic t_clear_unread();
    do_write(8'h00);
    chk("R4 clear without read", 8'h84);
  endtask

  task automatic t_clear_after_read();
    do_read();
    chk("R5 read leaves value", 8'h84);
    do_write(8'h00);
    chk("R5 clear after read", 8'h04);
  endtask

  task automatic t_sets();
    do_set(5'b01000); chk("R2 rx full", 8'h44);
    do_set(5'b00100); chk("R2 overrun", 8'h64);
    do_set(5'b00010); chk("R2 frame", 8'h74);
    do_set(5'b00001); chk("R2 parity", 8'h7C);
    do_set(5'b10000); chk("R2 tx empty", 8'hFC);
  endtask

  task automatic t_partial_clear();
    do_read();
    do_write(8'hDF);
    chk("R5 partial clear with MPBT", 8'hDD);
    n_chk++;
    if (mpbt_o !== 1'b1) begin
      n_err++; $display("FAIL R8: mpbt_o=%b expected=1", mpbt_o);
    end
  endtask

  task automatic t_race();
    @(negedge clk); ev = 5'b01000; wr_en = 1; wdata = 8'hBF; @(negedge clk); idle();
    chk("R6 set beats clear", 8'hDD);
    do_write(8'hBD);
    chk("R6 re-set cancels read", 8'hDD);
    do_read();
    do_write(8'hBD);
    chk("R5 clear after fresh read", 8'h9D);
  endtask

  task automatic t_read_while_zero();
    do_read();
    do_set(5'b00100);
    chk("R2 overrun again", 8'hBD);
    do_write(8'hDD);
    chk("R4 read while zero does not arm", 8'hBD);
  endtask

  task automatic t_ctl_bits();
    do_write(8'hFA);
    chk("R7 R8 ro bits hold, MPBT 0", 8'hBC);
    @(negedge clk); te_clr = 1; @(negedge clk); idle();
    chk("R7 tend clear", 8'hB8);
    @(negedge clk); mpb_ld = 1; mpb_v = 1; @(negedge clk); idle();
    chk("R7 mpb load", 8'hBA);
    do_write(8'hFD);
    chk("R7 R8 write ignored on ro bits", 8'hBB);
    @(negedge clk); te_set = 1; @(negedge clk); idle();
    chk("R7 tend set", 8'hBF);
  endtask

  task automatic t_manual();
    @(negedge clk); man_rst = 1; @(negedge clk); @(negedge clk); idle();
    chk("R10 manual reset ignored", 8'hBF);
  endtask

  task automatic t_standby();
    @(negedge clk); sw_stby = 1; @(negedge clk); idle();
    chk("R9 sw standby", 8'h84);
    do_write(8'h00);
    chk("R9 standby cancels read", 8'h84);
    do_set(5'b00001);
    chk("R2 parity after standby", 8'h8C);
    @(negedge clk); hw_stby = 1; @(negedge clk); idle();
    chk("R9 hw standby", 8'h84);
  endtask

  task automatic t_async_reset();
    do_set(5'b01110);
    chk("R2 multi set", 8'hF4);
    #2 rst_n = 0; #1;
    chk("R1 async reset", 8'h84);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 8'h84);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R1 during reset", 8'h84);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_ones();
    t_clear_unread();
    t_clear_after_read();
    t_sets();
    t_partial_clear();
    t_race();
    t_read_while_zero();
    t_ctl_bits();
    t_manual();
    t_standby();
    t_async_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule